// File: doc/BRIEF.md
# Heartbeat Handshake Fault Supervisor

This block is a small, always-powered supervisor that watches an application processor through a four-phase request/acknowledge handshake. The processor raises a request line. The supervisor answers on an acknowledge line. The processor drops its request, and the supervisor then drops its acknowledge. The supervisor also owns the processor's power-enable and active-low reset lines. Every wait in the exchange is bounded by a timeout. A timeout, or a line found at the wrong level, is recorded as a fault with a distinguishing error code.

A mode bit is captured when the processor is powered up, and it selects one of two policies. In coordinator mode the processor never sleeps, so the handshake acts as a periodic heartbeat. After each completed exchange a new heartbeat window opens. Any fault triggers recovery: power is removed for a fixed off period, restored, and then a reset pulse is issued. In end-device mode a completed exchange means the processor has finished its job, and the supervisor switches it off gracefully. A fault switches it off at once, and there is no retry. The processor stays off until the power-up input is pulsed again.

All delays and timeouts are parameters counted in clock cycles. The request input is asynchronous and passes through a two-stage synchronizer before any decision is taken on it.

Top module: `hb_supervisor`

## Requirements
- R1: After reset, `ack_o`=0, `pwr_en_o`=0, `rst_n_o`=1 and `err_code_o`=0. These values hold until `power_up_i` is seen high.
- R2: When the block is off, a cycle with `power_up_i`=1 raises `pwr_en_o` at the next edge. The same edge drives `rst_n_o` low for exactly `RST_CYC` cycles. In any other state `power_up_i` has no effect.
- R3: `ack_o` rises on the third rising edge after `req_i` goes high: two synchronizer stages, then the state register.
- R4: If the synchronized request is seen low within the first `MAX_HIGH_CYC` cycles after `ack_o` rose, `ack_o` falls on the third edge after `req_i` falls. `pwr_en_o` stays high.
- R5: The heartbeat window lasts `BEAT_CYC` cycles from power-up release or from the previous completion. If no synchronized request is seen in that window, error code 1 (missed request) is raised.
- R6: If the synchronized request is first seen low at cycle index `MAX_HIGH_CYC` or later after `ack_o` rose (index 0 = first cycle with `ack_o` high), but before the fall timeout, error code 2 (request too long) is raised.
- R7: If the request is still high in the `FALL_CYC`-th cycle with `ack_o` high, error code 3 (request never fell) is raised.
- R8: After `ack_o` falls, the request must stay low for `QUIET_CYC` cycles. A synchronized high in that window raises error code 4 (wrong line level).
- R9: In coordinator mode (mode bit 0), a fault drops `ack_o` and `pwr_en_o` for exactly `OFF_CYC` cycles. Then `pwr_en_o` returns high, `rst_n_o` is held low for `RST_CYC` cycles, and a new heartbeat window starts.
- R10: In end-device mode (mode bit 1), a completed handshake drives `pwr_en_o` low at the end of the quiet window, and the block returns to off.
- R11: In end-device mode a fault drives `pwr_en_o` low at once. There is no power-on retry and no reset pulse until `power_up_i` is pulsed again.
- R12: `err_code_o` takes a fault's code on the edge the fault is taken. It keeps that code through recovery and power-off. It returns to 0 only when a handshake completes.
- R13: The mode is sampled from `mode_i` only on the accepted power-up. Later changes of `mode_i` do not alter the policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Policy select, captured at power-up: 0 coordinator, 1 end device |
| power_up_i | input | 1 | Wake request; accepted only while the processor is off |
| req_i | input | 1 | Asynchronous handshake request from the processor, active high |
| ack_o | output | 1 | Handshake acknowledge to the processor, active high |
| pwr_en_o | output | 1 | Processor power enable, active high |
| rst_n_o | output | 1 | Processor reset, active low |
| err_code_o | output | 3 | Last fault code: 0 none, 1 missed, 2 too long, 3 never fell, 4 wrong level |

## Verification
The hardest situations to reach are the exact cycles that separate one outcome from another. One is a request that lands in the last cycle of the heartbeat window. The other is a request fall that lands on the boundary between an acceptable pulse and a too-long one, or between a too-long pulse and a stuck one. The bench reaches them by sweeping the request delay and the request width one cycle at a time over a small configuration. For each step it predicts the outcome from the window lengths and from the fixed latency of the two synchronizer stages plus the state register. Each sweep point starts from a fresh reset and power-up, so the recovery and power-off paths are exercised from a known cycle.

// File: rtl/hb_sup_pkg.sv
package hb_sup_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_RESET   = 3'd1,
        ST_WAIT    = 3'd2,
        ST_ACKED   = 3'd3,
        ST_QUIET   = 3'd4,
        ST_RECOVER = 3'd5
    } hb_state_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_MISSED  = 3'd1,
        ERR_LONG    = 3'd2,
        ERR_NO_FALL = 3'd3,
        ERR_LEVEL   = 3'd4
    } hb_err_e;

    typedef enum logic {
        MODE_COORD  = 1'b0,
        MODE_ENDDEV = 1'b1
    } hb_mode_e;

    typedef struct packed {
        logic ack;
        logic pwr_en;
        logic rst_n;
    } hb_lines_t;

    function automatic int unsigned hb_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Line levels driven toward the processor in each state.
    function automatic hb_lines_t hb_lines(input hb_state_e s);
        hb_lines_t l;
        l.ack    = (s == ST_ACKED);
        l.pwr_en = (s == ST_RESET) || (s == ST_WAIT) || (s == ST_ACKED) || (s == ST_QUIET);
        l.rst_n  = (s != ST_RESET);
        return l;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hb_timer.sv
module hb_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign count   = cnt_q;
    assign expired = (cnt_q == '0);
endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
    import hb_sup_pkg::*;
#(
    parameter int CW           = 8,
    parameter int BEAT_CYC     = 12,
    parameter int MAX_HIGH_CYC = 6,
    parameter int FALL_CYC     = 10,
    parameter int QUIET_CYC    = 4,
    parameter int OFF_CYC      = 8,
    parameter int RST_CYC      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_i,
    input  logic          power_up_i,
    input  logic          req_s,
    input  logic [CW-1:0] tmr_count,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          ack_o,
    output logic          pwr_en_o,
    output logic          rst_n_o,
    output logic [2:0]    err_code_o
);
    localparam logic [CW-1:0] LD_BEAT  = CW'(BEAT_CYC - 1);
    localparam logic [CW-1:0] LD_FALL  = CW'(FALL_CYC - 1);
    localparam logic [CW-1:0] LD_QUIET = CW'(QUIET_CYC - 1);
    localparam logic [CW-1:0] LD_OFF   = CW'(OFF_CYC - 1);
    localparam logic [CW-1:0] LD_RST   = CW'(RST_CYC - 1);
    // Remaining count at or below which a fall counts as late.
    localparam logic [CW-1:0] LATE_LIM = CW'(FALL_CYC - 1 - MAX_HIGH_CYC);

    hb_state_e st_q, st_d;
    hb_err_e   err_q, err_d;
    hb_mode_e  mode_q, mode_d;
    hb_err_e   fault_code;
    logic      fault;
    hb_lines_t lines;

    always_comb begin
        st_d       = st_q;
        err_d      = err_q;
        mode_d     = mode_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        fault      = 1'b0;
        fault_code = ERR_NONE;
        case (st_q)
            ST_OFF: begin
                if (power_up_i) begin
                    st_d     = ST_RESET;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RST;
                    mode_d   = hb_mode_e'(mode_i);
                end
            end
            ST_RESET: begin
                if (tmr_expired) begin
                    st_d     = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_BEAT;
                end
            end
            ST_WAIT: begin
                if (req_s) begin
                    st_d     = ST_ACKED;
                    tmr_load = 1'b1;
                    tmr_val  = LD_FALL;
                end else if (tmr_expired) begin
                    fault      = 1'b1;
                    fault_code = ERR_MISSED;
                end
            end
            ST_ACKED: begin
                if (!req_s) begin
                    if (tmr_count > LATE_LIM) begin
                        st_d     = ST_QUIET;
                        tmr_load = 1'b1;
                        tmr_val  = LD_QUIET;
                    end else begin
                        fault      = 1'b1;
                        fault_code = ERR_LONG;
                    end
                end else if (tmr_expired) begin
                    fault      = 1'b1;
                    fault_code = ERR_NO_FALL;
                end
            end
            ST_QUIET: begin
                if (req_s) begin
                    fault      = 1'b1;
                    fault_code = ERR_LEVEL;
                end else if (tmr_expired) begin
                    err_d = ERR_NONE;
                    if (mode_q == MODE_COORD) begin
                        st_d     = ST_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = LD_BEAT;
                    end else begin
                        st_d = ST_OFF;
                    end
                end
            end
            ST_RECOVER: begin
                if (tmr_expired) begin
                    st_d     = ST_RESET;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RST;
                end
            end
            default: st_d = ST_OFF;
        endcase

        if (fault) begin
            err_d = fault_code;
            if (mode_q == MODE_COORD) begin
                st_d     = ST_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = LD_OFF;
            end else begin
                st_d = ST_OFF;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_OFF;
            err_q  <= ERR_NONE;
            mode_q <= MODE_COORD;
        end else begin
            st_q   <= st_d;
            err_q  <= err_d;
            mode_q <= mode_d;
        end
    end

    assign lines      = hb_lines(st_q);
    assign ack_o      = lines.ack;
    assign pwr_en_o   = lines.pwr_en;
    assign rst_n_o    = lines.rst_n;
    assign err_code_o = err_q;

    // Width of the current low phase of the processor reset line.
    logic [CW-1:0] rst_low_cnt;
    always_ff @(posedge clk) begin
        if (rst)           rst_low_cnt <= '0;
        else if (!rst_n_o) rst_low_cnt <= rst_low_cnt + 1'b1;
        else               rst_low_cnt <= '0;
    end

    assert_reset_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_o) |-> (rst_low_cnt == CW'(RST_CYC)));

    assert_ack_after_req_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> $past(req_s));

    assert_ack_drop_clean_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_o) && pwr_en_o) |-> !$past(req_s));

    assert_missed_from_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (err_code_o == ERR_MISSED && $past(err_code_o) != ERR_MISSED) |-> $past(st_q == ST_WAIT));

    assert_nofall_from_acked_R7: assert property (@(posedge clk) disable iff (rst)
        (err_code_o == ERR_NO_FALL && $past(err_code_o) != ERR_NO_FALL) |-> $past(req_s));

    assert_level_from_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (err_code_o == ERR_LEVEL && $past(err_code_o) != ERR_LEVEL) |-> $past(st_q == ST_QUIET));

    assert_clear_on_done_R12: assert property (@(posedge clk) disable iff (rst)
        (err_code_o == ERR_NONE && $past(err_code_o) != ERR_NONE) |-> $past(st_q == ST_QUIET && !req_s));
endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
    import hb_sup_pkg::*;
#(
    parameter int BEAT_CYC     = 125_000_000,
    parameter int MAX_HIGH_CYC = 1_250,
    parameter int FALL_CYC     = 12_500,
    parameter int QUIET_CYC    = 125,
    parameter int OFF_CYC      = 250_000_000,
    parameter int RST_CYC      = 50,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_i,
    input  logic       power_up_i,
    input  logic       req_i,
    output logic       ack_o,
    output logic       pwr_en_o,
    output logic       rst_n_o,
    output logic [2:0] err_code_o
);
    localparam int unsigned MAX_LOAD =
        hb_max(hb_max(hb_max(BEAT_CYC, FALL_CYC), hb_max(QUIET_CYC, OFF_CYC)), RST_CYC);
    localparam int CW = (MAX_LOAD < 2) ? 1 : $clog2(MAX_LOAD + 1);

    logic          req_s;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic [CW-1:0] tmr_count;
    logic          tmr_expired;

    hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (req_i),
        .dout (req_s)
    );

    hb_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_count),
        .expired  (tmr_expired)
    );

    hb_fsm #(
        .CW           (CW),
        .BEAT_CYC     (BEAT_CYC),
        .MAX_HIGH_CYC (MAX_HIGH_CYC),
        .FALL_CYC     (FALL_CYC),
        .QUIET_CYC    (QUIET_CYC),
        .OFF_CYC      (OFF_CYC),
        .RST_CYC      (RST_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_i),
        .power_up_i  (power_up_i),
        .req_s       (req_s),
        .tmr_count   (tmr_count),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .ack_o       (ack_o),
        .pwr_en_o    (pwr_en_o),
        .rst_n_o     (rst_n_o),
        .err_code_o  (err_code_o)
    );
endmodule

// File: tb/hb_supervisor_bench.sv
module hb_supervisor_bench;
    localparam int BEAT  = 12;
    localparam int MAXH  = 6;
    localparam int FALL  = 10;
    localparam int QUIET = 4;
    localparam int OFFC  = 8;
    localparam int RSTC  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_i = 1'b0;
    logic       power_up_i = 1'b0;
    logic       req_i = 1'b0;
    logic       ack_o, pwr_en_o, rst_n_o;
    logic [2:0] err_code_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hb_supervisor #(
        .BEAT_CYC(BEAT), .MAX_HIGH_CYC(MAXH), .FALL_CYC(FALL),
        .QUIET_CYC(QUIET), .OFF_CYC(OFFC), .RST_CYC(RSTC), .SYNC_STAGES(2)
    ) u_hb_supervisor (
        .clk(clk), .rst(rst), .mode_i(mode_i), .power_up_i(power_up_i),
        .req_i(req_i), .ack_o(ack_o), .pwr_en_o(pwr_en_o),
        .rst_n_o(rst_n_o), .err_code_o(err_code_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset, then power up; returns at the first cycle of the heartbeat window.
    task automatic start(input bit m);
        rst = 1'b1; req_i = 1'b0; power_up_i = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 ack", ack_o, 0); chk("R1 pwr", pwr_en_o, 0);
        chk("R1 rst_n", rst_n_o, 1); chk("R1 err", err_code_o, 0);
        step(3);
        chk("R1 stays off", pwr_en_o, 0);
        mode_i = m; power_up_i = 1'b1;
        step(1);
        power_up_i = 1'b0;
        chk("R2 pwr up", pwr_en_o, 1); chk("R2 rst low", rst_n_o, 0);
        step(RSTC - 1);
        chk("R2 rst still low", rst_n_o, 0);
        step(1);
        chk("R2 rst released", rst_n_o, 1); chk("R2 pwr held", pwr_en_o, 1);
    endtask

    // Called on the first cycle after a fault was taken.
    task automatic after_fault(input bit m);
        if (!m) begin
            chk("R9 ack low", ack_o, 0); chk("R9 pwr low", pwr_en_o, 0);
            step(OFFC - 1);
            chk("R9 off span", pwr_en_o, 0);
            step(1);
            chk("R9 pwr back", pwr_en_o, 1); chk("R9 rst low", rst_n_o, 0);
            step(RSTC - 1);
            chk("R9 rst span", rst_n_o, 0);
            step(1);
            chk("R9 rst released", rst_n_o, 1);
        end else begin
            chk("R11 pwr low", pwr_en_o, 0);
            step(OFFC + RSTC + 4);
            chk("R11 no retry pwr", pwr_en_o, 0); chk("R11 no reset", rst_n_o, 1);
        end
    endtask

    // Start at window index 0; request after d cycles, released after h cycles of ack.
    task automatic hs(input bit m, input int d, input int h);
        step(d);
        req_i = 1'b1;
        step(2);
        chk("R3 ack not yet", ack_o, 0);
        step(1);
        chk("R3 ack raised", ack_o, 1);
        if (h >= FALL - 2) begin
            step(FALL - 1);
            chk("R7 ack still high", ack_o, 1);
            step(1);
            chk("R7 code", err_code_o, 3); chk("R7 ack low", ack_o, 0);
            req_i = 1'b0;
            after_fault(m);
            chk("R12 code held", err_code_o, 3);
        end else begin
            step(h);
            req_i = 1'b0;
            step(2);
            chk("R4 ack held", ack_o, 1);
            step(1);
            if (h + 2 < MAXH) begin
                chk("R4 ack dropped", ack_o, 0); chk("R4 pwr kept", pwr_en_o, 1);
                step(QUIET - 1);
                chk("R8 quiet pwr", pwr_en_o, 1);
                step(1);
                chk("R12 cleared", err_code_o, 0);
                chk("R10 pwr after done", pwr_en_o, m ? 0 : 1);
            end else begin
                chk("R6 code", err_code_o, 2); chk("R6 ack low", ack_o, 0);
                after_fault(m);
                chk("R12 code held", err_code_o, 2);
            end
        end
    endtask

    initial begin
        step(1);
        // R5: request delay swept across the heartbeat window.
        for (int d = 0; d <= BEAT; d++) begin
            start(1'b0);
            if (d <= BEAT - 3) begin
                hs(1'b0, d, 0);
            end else begin
                if (d < BEAT) begin
                    step(d);
                    req_i = 1'b1;
                    step(BEAT - 1 - d);
                end else begin
                    step(BEAT - 1);
                end
                chk("R5 window open", pwr_en_o, 1); chk("R5 no ack", ack_o, 0);
                step(1);
                chk("R5 missed code", err_code_o, 1);
                req_i = 1'b0;
                after_fault(1'b0);
                chk("R12 held after recovery", err_code_o, 1);
                hs(1'b0, 0, 0);
            end
        end
        // R4 R6 R7: request width swept in both modes.
        for (int m = 0; m < 2; m++) begin
            for (int h = 0; h <= FALL; h++) begin
                start(m[0]);
                hs(m[0], 1, h);
            end
        end
        // R8: request rising again inside the quiet window.
        for (int m = 0; m < 2; m++) begin
            start(m[0]);
            req_i = 1'b1;
            step(3);
            chk("R8 ack up", ack_o, 1);
            req_i = 1'b0;
            step(3);
            chk("R8 ack down", ack_o, 0);
            req_i = 1'b1;
            step(2);
            chk("R8 not yet", err_code_o, 0);
            step(1);
            chk("R8 level code", err_code_o, 4);
            req_i = 1'b0;
            after_fault(m[0]);
        end
        // R2 and R13: power-up ignored while on; mode latched at power-up.
        start(1'b1);
        mode_i = 1'b0; power_up_i = 1'b1;
        step(1);
        power_up_i = 1'b0;
        chk("R2 ignored while on", rst_n_o, 1);
        hs(1'b1, 0, 0);
        chk("R13 latched end-device", pwr_en_o, 0);
        // R11: end-device miss, then wake again and complete.
        start(1'b1);
        step(BEAT);
        chk("R11 missed code", err_code_o, 1);
        after_fault(1'b1);
        mode_i = 1'b1; power_up_i = 1'b1;
        step(1);
        power_up_i = 1'b0;
        chk("R11 wake pwr", pwr_en_o, 1); chk("R11 wake rst", rst_n_o, 0);
        step(RSTC);
        chk("R12 kept over wake", err_code_o, 1);
        hs(1'b1, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1-scope run hung: got 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule